// File: doc/BRIEF.md
# Transmit Path Overhead Byte Inserter

This block sits in the transmit direction of one STS-3/STM-1 AU-4 path and rewrites the path overhead bytes as they go by on a byte stream. Along with each byte, an upstream framer supplies an overhead-valid strobe and a 4-bit position code. These say whether the byte is an overhead byte and, if so, which one. The block does not generate B3 parity and does not process pointers.

For C2, G1, F2, H4, F3, K3 and N1, the outgoing byte comes from one of three sources:
- a software-written register, when that byte's insert bit is set;
- the overhead access channel byte, when the insert bit is clear and the channel is enabled;
- a fixed default otherwise.

J1 can instead carry a 64-byte trace that moves on by one byte per frame. A remote error indication, derived from the receive side's B3 error count, is merged into G1 unless it is inhibited. A pass-through bit hands the whole path overhead, including H1 to H3, from the low-speed input to the output untouched.

Three per-port control sets arrive at the ports. In AU-4 mode only the first set (port index 0) has any effect. Every byte leaves one clock after it enters.

Top module: `poh_inserter`

## Requirements
- R1: While reset is asserted, out_byte is 0x00 and out_oh_valid is 0. After reset, the J1 trace index points at trace byte 1 (bits [7:0] of cfg_j1_trace).
- R2: Bytes with in_oh_valid = 0, bytes at position code 1 (B3) and bytes at unused codes 12 to 15 leave unchanged one cycle later. out_oh_valid and out_oh_pos are the inputs delayed by one cycle.
- R3: Position codes are 2 = C2, 3 = G1, 4 = F2, 5 = H4, 6 = F3, 7 = K3 and 8 = N1. Each is slot 0 to 6 in that order. For slot s, insert bit cfg_ins[s+1] = 1 makes the byte the register value cfg_vals[8s+7:8s].
- R4: When a byte's insert bit is 0 and oac_en = 1, the byte is oac_byte. The same holds for J1 (code 0) with insert bit cfg_ins[0].
- R5: When the insert bit is 0 and oac_en = 0, the byte is its default: C2 = 0x01, and 0x00 for J1, G1, F2, H4, F3, K3 and N1.
- R6: With cfg_ins[0] = 1, the J1 byte is trace byte k+1 (cfg_j1_trace[8k+7:8k]) for the current index k. Each in_frame_start pulse advances the index after that cycle, and the index wraps from 63 to 0.
- R7: A 0-to-1 change of cfg_ins[0] returns the index to 0 (trace byte 1), even when in_frame_start is high in the same cycle.
- R8: Unless cfg_rei_inh[0] = 1, G1 bits [7:4] carry min(rx_b3_err_cnt, 8). G1 bits [3:0] come from the G1 source chosen under R3 to R5.
- R9: With cfg_rei_inh[0] = 1, all of G1 comes from its selected source.
- R10: With cfg_thru[0] = 1, every overhead position (codes 0 to 11, including H1 = 9, H2 = 10, H3 = 11) leaves unchanged. This overrides the insert bits and the REI.
- R11: Control bits and register values for port indices 1 and 2 have no effect. These are cfg_ins[23:8], cfg_thru[2:1], cfg_rei_inh[2:1] and cfg_vals[167:56].
- R12: Without pass-through, H1, H2 and H3 are sent as 0x6A, 0x0A and 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | 8 | Byte from the low-speed side |
| in_oh_valid | input | 1 | Byte is a path overhead position |
| in_oh_pos | input | 4 | Overhead position code |
| in_frame_start | input | 1 | Frame-start pulse, advances the J1 trace |
| oac_en | input | 1 | Overhead access channel enabled |
| oac_byte | input | 8 | Access channel byte for the current position |
| rx_b3_err_cnt | input | 4 | Received B3 error count |
| cfg_ins | input | 24 | Insert bits, 8 per port (bit 0 J1, bits 1..7 slots) |
| cfg_thru | input | 3 | Pass-through bit per port |
| cfg_rei_inh | input | 3 | REI inhibit per port |
| cfg_vals | input | 168 | Register bytes, 7 per port |
| cfg_j1_trace | input | 512 | 64-byte J1 trace |
| out_byte | output | 8 | Byte to the high-speed side |
| out_oh_valid | output | 1 | Delayed overhead strobe |
| out_oh_pos | output | 4 | Delayed position code |

## Verification
Two things can land in the same cycle:
- The J1 trace index can be told to restart (a rising J1 insert bit) and to advance (a frame-start pulse) together. The bench advances the index away from zero, drops the insert bit, then raises it on the same edge as a frame pulse. It checks that the next J1 byte is trace byte 1 and not byte 2.
- G1 can take a software register value and the REI in one byte. The bench sweeps all sixteen error counts with a register value whose low nibble differs from its high nibble. It checks that the upper nibble holds the clamped count and the lower nibble is the register's.

// File: rtl/poh_pkg.sv
`timescale 1ns/1ps
package poh_pkg;
  localparam int BW    = 8;
  localparam int NSLOT = 7;
  localparam int CTLW  = NSLOT + 1;

  localparam logic [3:0] POS_J1 = 4'd0;
  localparam logic [3:0] POS_B3 = 4'd1;
  localparam logic [3:0] POS_C2 = 4'd2;
  localparam logic [3:0] POS_G1 = 4'd3;
  localparam logic [3:0] POS_N1 = 4'd8;
  localparam logic [3:0] POS_H1 = 4'd9;
  localparam logic [3:0] POS_H2 = 4'd10;
  localparam logic [3:0] POS_H3 = 4'd11;

  // clamp of the B3 error count into the 4-bit REI field
  function automatic logic [3:0] rei_of(input logic [3:0] cnt, input logic [3:0] lim);
    rei_of = (cnt > lim) ? lim : cnt;
  endfunction

  function automatic logic is_slot(input logic [3:0] pos);
    is_slot = (pos >= POS_C2) && (pos <= POS_N1);
  endfunction

  function automatic logic [2:0] slot_of(input logic [3:0] pos);
    logic [3:0] d;
    d = pos - POS_C2;
    slot_of = d[2:0];
  endfunction

  function automatic logic [BW-1:0] slot_default(input int s, input logic [BW-1:0] c2_def);
    slot_default = (s == 0) ? c2_def : '0;
  endfunction
endpackage

// File: rtl/poh_j1_trace.sv
`timescale 1ns/1ps
module poh_j1_trace #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               j1_ctl,
  input  logic [DEPTH*W-1:0] trace,
  output logic [W-1:0]       trace_byte,
  output logic [IW-1:0]      idx,
  output logic               restart
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic ctl_q;

  assign restart    = j1_ctl & ~ctl_q;
  assign trace_byte = trace[int'(idx)*W +: W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= 1'b0;
      idx   <= '0;
    end else begin
      ctl_q <= j1_ctl;
      if (restart)
        idx <= '0;
      else if (frame_start)
        idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end
  end
endmodule

// File: rtl/poh_src_sel.sv
`timescale 1ns/1ps
module poh_src_sel
  import poh_pkg::*;
#(
  parameter logic [BW-1:0] C2_DEF = 8'h01,
  parameter logic [BW-1:0] J1_DEF = 8'h00
) (
  input  logic [3:0]          pos,
  input  logic [CTLW-1:0]     ins_ctl,
  input  logic [NSLOT*BW-1:0] reg_vals,
  input  logic                oac_en,
  input  logic [BW-1:0]       oac_byte,
  input  logic [BW-1:0]       trace_byte,
  output logic [BW-1:0]       j1_byte,
  output logic [BW-1:0]       slot_byte
);
  logic [BW-1:0] cand [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign cand[s] = ins_ctl[s+1] ? reg_vals[s*BW +: BW]
                   : (oac_en ? oac_byte : slot_default(s, C2_DEF));
  end

  assign j1_byte = ins_ctl[0] ? trace_byte : (oac_en ? oac_byte : J1_DEF);

  always_comb begin
    slot_byte = '0;
    if (is_slot(pos) && (int'(slot_of(pos)) < NSLOT))
      slot_byte = cand[slot_of(pos)];
  end
endmodule

// File: rtl/poh_rei_merge.sv
`timescale 1ns/1ps
module poh_rei_merge
  import poh_pkg::*;
#(
  parameter logic [3:0] REI_MAX = 4'd8
) (
  input  logic [BW-1:0] g1_src,
  input  logic [3:0]    err_cnt,
  input  logic          inhibit,
  output logic [BW-1:0] g1_out
);
  assign g1_out = inhibit ? g1_src : {rei_of(err_cnt, REI_MAX), g1_src[3:0]};
endmodule

// File: rtl/poh_inserter.sv
`timescale 1ns/1ps
module poh_inserter
  import poh_pkg::*;
#(
  parameter int          NPORT    = 3,
  parameter int          SEL_PORT = 0,
  parameter int          TDEPTH   = 64,
  parameter logic [7:0]  H1_FIX   = 8'h6A,
  parameter logic [7:0]  H2_FIX   = 8'h0A,
  parameter logic [7:0]  H3_FIX   = 8'h00,
  localparam int         TIW      = $clog2(TDEPTH),
  localparam int         PSW      = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BW-1:0]             in_byte,
  input  logic                      in_oh_valid,
  input  logic [3:0]                in_oh_pos,
  input  logic                      in_frame_start,
  input  logic                      oac_en,
  input  logic [BW-1:0]             oac_byte,
  input  logic [3:0]                rx_b3_err_cnt,
  input  logic [NPORT*CTLW-1:0]     cfg_ins,
  input  logic [NPORT-1:0]          cfg_thru,
  input  logic [NPORT-1:0]          cfg_rei_inh,
  input  logic [NPORT*NSLOT*BW-1:0] cfg_vals,
  input  logic [TDEPTH*BW-1:0]      cfg_j1_trace,
  output logic [BW-1:0]             out_byte,
  output logic                      out_oh_valid,
  output logic [3:0]                out_oh_pos
);
  // port selector for the control set in force (AU-4: one set)
  logic [PSW-1:0]          port_sel;
  logic [CTLW-1:0]         ins_eff;
  logic [NSLOT*BW-1:0]     vals_eff;
  logic                    thru_eff;
  logic                    rei_inh_eff;
  logic [BW-1:0]           trace_byte, j1_byte, slot_byte, g1_merged, next_byte;
  logic [TIW-1:0]          trace_idx;
  logic                    j1_restart;

  assign port_sel    = PSW'(SEL_PORT);
  assign ins_eff     = cfg_ins[int'(port_sel)*CTLW +: CTLW];
  assign vals_eff    = cfg_vals[int'(port_sel)*NSLOT*BW +: NSLOT*BW];
  assign thru_eff    = cfg_thru[port_sel];
  assign rei_inh_eff = cfg_rei_inh[port_sel];

  poh_j1_trace #(.DEPTH(TDEPTH), .W(BW)) u_trace (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (in_frame_start),
    .j1_ctl      (ins_eff[0]),
    .trace       (cfg_j1_trace),
    .trace_byte  (trace_byte),
    .idx         (trace_idx),
    .restart     (j1_restart)
  );

  poh_src_sel u_sel (
    .pos        (in_oh_pos),
    .ins_ctl    (ins_eff),
    .reg_vals   (vals_eff),
    .oac_en     (oac_en),
    .oac_byte   (oac_byte),
    .trace_byte (trace_byte),
    .j1_byte    (j1_byte),
    .slot_byte  (slot_byte)
  );

  poh_rei_merge u_rei (
    .g1_src  (slot_byte),
    .err_cnt (rx_b3_err_cnt),
    .inhibit (rei_inh_eff),
    .g1_out  (g1_merged)
  );

  always_comb begin
    next_byte = in_byte;
    if (in_oh_valid && !thru_eff) begin
      case (in_oh_pos)
        POS_J1:  next_byte = j1_byte;
        POS_G1:  next_byte = g1_merged;
        POS_H1:  next_byte = H1_FIX;
        POS_H2:  next_byte = H2_FIX;
        POS_H3:  next_byte = H3_FIX;
        default: if (is_slot(in_oh_pos)) next_byte = slot_byte;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_byte     <= '0;
      out_oh_valid <= 1'b0;
      out_oh_pos   <= '0;
    end else begin
      out_byte     <= next_byte;
      out_oh_valid <= in_oh_valid;
      out_oh_pos   <= in_oh_pos;
    end
  end
endmodule

// File: rtl/poh_inserter_chk.sv
`timescale 1ns/1ps
module poh_inserter_chk #(
  parameter int IW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    in_byte,
  input logic          in_oh_valid,
  input logic [3:0]    in_oh_pos,
  input logic          in_frame_start,
  input logic [3:0]    rx_b3_err_cnt,
  input logic          thru_eff,
  input logic          rei_inh_eff,
  input logic [IW-1:0] trace_idx,
  input logic          j1_restart,
  input logic [7:0]    out_byte,
  input logic          out_oh_valid
);
  localparam logic [IW-1:0] LAST = {IW{1'b1}};

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_oh_valid |=> out_oh_valid);
  p_valid_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_oh_valid |=> !out_oh_valid);
  p_payload_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_oh_valid |=> out_byte == $past(in_byte));
  p_b3_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_oh_valid && in_oh_pos == 4'd1) |=> out_byte == $past(in_byte));
  p_thru_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_oh_valid && thru_eff) |=> out_byte == $past(in_byte));
  p_rei_field_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_oh_valid && !thru_eff && !rei_inh_eff && in_oh_pos == 4'd3)
    |=> out_byte[7:4] == (($past(rx_b3_err_cnt) > 4'd8) ? 4'd8 : $past(rx_b3_err_cnt)));
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    j1_restart |=> trace_idx == '0);
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame_start && !j1_restart && trace_idx == LAST) |=> trace_idx == '0);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frame_start && !j1_restart) |=> $stable(trace_idx));
endmodule

bind poh_inserter poh_inserter_chk #(.IW(TIW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_byte        (in_byte),
  .in_oh_valid    (in_oh_valid),
  .in_oh_pos      (in_oh_pos),
  .in_frame_start (in_frame_start),
  .rx_b3_err_cnt  (rx_b3_err_cnt),
  .thru_eff       (thru_eff),
  .rei_inh_eff    (rei_inh_eff),
  .trace_idx      (trace_idx),
  .j1_restart     (j1_restart),
  .out_byte       (out_byte),
  .out_oh_valid   (out_oh_valid)
);

// File: tb/sim_poh_inserter.sv
`timescale 1ns/1ps
module sim_poh_inserter;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   in_byte = '0;
  logic         in_oh_valid = 1'b0;
  logic [3:0]   in_oh_pos = '0;
  logic         in_frame_start = 1'b0;
  logic         oac_en = 1'b0;
  logic [7:0]   oac_byte = '0;
  logic [3:0]   rx_b3_err_cnt = '0;
  logic [23:0]  cfg_ins = '0;
  logic [2:0]   cfg_thru = '0;
  logic [2:0]   cfg_rei_inh = '0;
  logic [167:0] cfg_vals = '0;
  logic [511:0] cfg_j1_trace = '0;
  logic [7:0]   out_byte;
  logic         out_oh_valid;
  logic [3:0]   out_oh_pos;

  int n_cmp = 0;
  int n_bad = 0;
  int m_idx = 0;
  logic m_prev = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  poh_inserter u0 (.*);

  function automatic logic [7:0] slot_reg(int s);
    return cfg_vals[s*8 +: 8];
  endfunction

  // expected output byte per the requirements (port index 0 only)
  function automatic logic [7:0] expect_byte(logic [7:0] b, logic v, logic [3:0] p);
    logic [7:0] src;
    int s;
    if (!v || cfg_thru[0] || p == 4'd1 || p > 4'd11) return b;
    if (p == 4'd9)  return 8'h6A;
    if (p == 4'd10) return 8'h0A;
    if (p == 4'd11) return 8'h00;
    if (p == 4'd0) begin
      if (cfg_ins[0]) return cfg_j1_trace[m_idx*8 +: 8];
      return oac_en ? oac_byte : 8'h00;
    end
    s = int'(p) - 2;
    if (cfg_ins[s+1])  src = slot_reg(s);
    else if (oac_en)   src = oac_byte;
    else               src = (s == 0) ? 8'h01 : 8'h00;
    if (p == 4'd3 && !cfg_rei_inh[0])
      src[7:4] = (rx_b3_err_cnt > 4'd8) ? 4'd8 : rx_b3_err_cnt;
    return src;
  endfunction

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual valid/pos/byte=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(logic [7:0] b, logic v, logic [3:0] p, logic fs, string tag);
    logic [7:0] e;
    in_byte = b; in_oh_valid = v; in_oh_pos = p; in_frame_start = fs;
    e = expect_byte(b, v, p);
    @(posedge clk);
    if (cfg_ins[0] && !m_prev) m_idx = 0;
    else if (fs) m_idx = (m_idx + 1) % 64;
    m_prev = cfg_ins[0];
    @(negedge clk);
    check(tag, {out_oh_pos, out_byte}, {p, e});
    if (out_oh_valid !== v) check(tag, {3'b0, out_oh_valid, 8'h00}, {3'b0, v, 8'h00});
  endtask

  task automatic scramble_other_ports();
    cfg_ins[23:8]     = 16'($urandom);
    cfg_thru[2:1]     = 2'($urandom);
    cfg_rei_inh[2:1]  = 2'($urandom);
    for (int i = 7; i < 21; i++) cfg_vals[i*8 +: 8] = 8'($urandom);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) cfg_j1_trace[i*8 +: 8] = 8'(i * 7 + 3);
    for (int i = 0; i < 21; i++) cfg_vals[i*8 +: 8] = 8'($urandom);
    cfg_ins[0] = 1'b1;
    in_byte = 8'hFF; 
    repeat (3) @(negedge clk);
    check("R1 reset", {out_oh_pos, out_byte}, 12'h000);
    check("R1 reset valid", {11'b0, out_oh_valid}, 12'h000);
    rst_n = 1'b1;
    // R1: first J1 after reset is trace byte 1
    step(8'h55, 1'b1, 4'd0, 1'b0, "R1 trace start");

    // R5: defaults
    cfg_ins[7:0] = 8'h00; oac_en = 1'b0; cfg_rei_inh[0] = 1'b1;
    for (int p = 0; p < 9; p++) if (p != 1) step(8'($urandom), 1'b1, 4'(p), 1'b0, "R5 default");

    // R4: access channel
    oac_en = 1'b1;
    for (int p = 0; p < 9; p++) if (p != 1) begin
      oac_byte = 8'($urandom);
      step(8'($urandom), 1'b1, 4'(p), 1'b0, "R4 oac");
    end

    // R3: register values
    cfg_ins[7:1] = 7'h7F;
    for (int p = 2; p < 9; p++) step(8'($urandom), 1'b1, 4'(p), 1'b0, "R3 register");

    // R12: fixed pointer bytes
    for (int p = 9; p < 12; p++) step(8'($urandom), 1'b1, 4'(p), 1'b0, "R12 pointer");

    // R2: payload, B3, unused codes
    step(8'hA5, 1'b0, 4'd3, 1'b0, "R2 payload");
    step(8'h3C, 1'b1, 4'd1, 1'b0, "R2 b3");
    for (int p = 12; p < 16; p++) step(8'($urandom), 1'b1, 4'(p), 1'b0, "R2 unused code");

    // R8: REI merged with register G1, all counts
    cfg_rei_inh[0] = 1'b0;
    cfg_vals[15:8] = 8'h5C;
    for (int c = 0; c < 16; c++) begin
      rx_b3_err_cnt = 4'(c);
      step(8'h00, 1'b1, 4'd3, 1'b0, "R8 rei clamp");
    end
    // R9: inhibit
    cfg_rei_inh[0] = 1'b1; rx_b3_err_cnt = 4'd15;
    step(8'h00, 1'b1, 4'd3, 1'b0, "R9 inhibit");

    // R10: pass-through of all positions
    cfg_thru[0] = 1'b1; cfg_rei_inh[0] = 1'b0;
    for (int p = 0; p < 12; p++) step(8'($urandom), 1'b1, 4'(p), 1'b0, "R10 thru");
    cfg_thru[0] = 1'b0;

    // R6: trace cycling and wrap over 130 frames
    cfg_ins[0] = 1'b1;
    for (int f = 0; f < 130; f++) begin
      step(8'h00, 1'b1, 4'd0, 1'b0, "R6 trace");
      step(8'h00, 1'b0, 4'd0, 1'b1, "R6 frame");
    end

    // R7: restart coincident with frame start
    for (int f = 0; f < 5; f++) step(8'h00, 1'b0, 4'd0, 1'b1, "R7 advance");
    cfg_ins[0] = 1'b0;
    step(8'h00, 1'b0, 4'd0, 1'b0, "R7 drop");
    cfg_ins[0] = 1'b1;
    step(8'h00, 1'b0, 4'd0, 1'b1, "R7 rise with frame");
    step(8'h00, 1'b1, 4'd0, 1'b0, "R7 restart byte");
    check("R7 index", {4'd0, out_byte}, {4'd0, cfg_j1_trace[7:0]});

    // R11: other ports change freely, port 0 steady
    cfg_ins[7:0] = 8'b1010_0101; cfg_rei_inh[0] = 1'b0;
    for (int k = 0; k < 200; k++) begin
      scramble_other_ports();
      rx_b3_err_cnt = 4'($urandom);
      oac_byte = 8'($urandom);
      step(8'($urandom), 1'($urandom), 4'($urandom_range(0, 11)), 1'($urandom), "R11 other ports");
    end

    // random mix covering R3 R4 R5 R6 R8 R9 R10
    for (int k = 0; k < 2000; k++) begin
      if ($urandom_range(0, 15) == 0) begin
        cfg_ins[7:0] = 8'($urandom);
        cfg_thru[0] = ($urandom_range(0, 7) == 0);
        cfg_rei_inh[0] = 1'($urandom);
        oac_en = 1'($urandom);
        for (int i = 0; i < 7; i++) cfg_vals[i*8 +: 8] = 8'($urandom);
      end
      scramble_other_ports();
      rx_b3_err_cnt = 4'($urandom);
      oac_byte = 8'($urandom);
      step(8'($urandom), ($urandom_range(0, 3) != 0), 4'($urandom),
           ($urandom_range(0, 9) == 0), "R3 R8 R10 random mix");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule